// File: doc/BRIEF.md
# Weight-Stationary Systolic MAC Grid

This block is a grid of multiply-accumulate elements of `ROWS` by `COLS`. Each element holds one signed weight. The weights stay in place for a tile, and the tile may cover several folds. One activation vector of `ROWS` signed values is placed on the rows. Partial sums then move down every column, one registered stage per row. The bottom row gives one accumulated dot product per column: `psum[c] = sum over r of act[r] * w[r][c]`.

A pulse on `start` begins a fold. The sequencer first loads the weights, unless `keepWeights` asks it to reuse the ones already held. It then loads the activations, runs the MAC phase and signals completion.

In the shifting mode, weights arrive one row per cycle and activations one value per cycle. Each pushes down the rows. In the parallel mode, the whole weight grid is written in one cycle. The activation vector is then multicast to all rows in one more cycle, so no forwarding cycles come before the MAC phase. The `wTake` and `aTake` outputs tell the feeder in which cycle its data is consumed.

Top module: `ws_array`

## Requirements
- R1: After reset, `busy`, `done`, `wTake` and `aTake` are 0 and every `psum` column is 0.
- R2: With `parMode`=1, `wTake` is high for exactly one cycle and captures all of `wData`, with weight (r,c) at bits `(r*COLS+c)*8`. `aTake` is then high for exactly one cycle and captures all of `aData`, with row r at bits `r*8`.
- R3: With `parMode`=0, `wTake` is high for `ROWS` consecutive cycles. Each cycle takes one row from `wData[COLS*8-1:0]`, with column c at bits `c*8`. The row supplied first ends up in the bottom row (`ROWS-1`), and the row supplied last ends up in row 0.
- R4: With `parMode`=0, `aTake` is high for `ROWS` consecutive cycles. Each cycle takes one value from `aData[7:0]`. The value supplied first ends up in the bottom row.
- R5: When `done` is high, column c of `psum` (bits `c*24` upward) equals `sum_r act[r]*w[r][c]` over 8-bit signed operands, wrapped to 24 bits.
- R6: `done` is a single-cycle pulse, and `busy` is low in that cycle. `psum` keeps its value while the block is idle.
- R7: Counting clock edges after the edge that samples `start`, `done` appears after `ROWS+2` edges in parallel mode and after `3*ROWS` edges in shifting mode. With `keepWeights`=1, these become `ROWS+1` and `2*ROWS`.
- R8: With `keepWeights`=1, `wTake` stays low and the result uses the weights of the previous load.
- R9: `start` is ignored while `busy` is high: it neither restarts nor extends the fold.
- R10: The MAC phase lasts exactly `ROWS` consecutive cycles, with one multiply-accumulate per element per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fold when idle |
| parMode | input | 1 | 1: parallel load and multicast, 0: shift-in load |
| keepWeights | input | 1 | Skip weight load and reuse the held weights |
| wData | input | ROWS*COLS*8 | Weight grid (parallel) or one row in the low bits (shift) |
| aData | input | ROWS*8 | Activation vector (parallel) or one value in the low byte (shift) |
| busy | output | 1 | A fold is in progress |
| wTake | output | 1 | Weight data is consumed at the coming edge |
| aTake | output | 1 | Activation data is consumed at the coming edge |
| done | output | 1 | Result valid pulse |
| psum | output | COLS*24 | Column sums of the bottom row |

## Verification
The reference model starts a latency counter at the edge that accepts `start`. It predicts `busy` and `done` for every cycle from the R7 latencies: `ROWS+2` or `3*ROWS` edges, less the weight phase when weights are kept. The bench compares both outputs at every falling edge, halfway between updates. Load data is driven at a falling edge only while `wTake` or `aTake` is already high, so each operand is settled one half-period before the edge that takes it. `psum` is compared with a software matrix-vector product in the `done` cycle and again three idle cycles later.

// File: rtl/ws_pkg.sv
package ws_pkg;

  // Strobes from the sequencer to the datapath, one per action.
  typedef struct packed {
    logic wShift;  // push one weight row in at the top
    logic wAll;    // write the whole weight grid
    logic aShift;  // push one activation in at the top
    logic aAll;    // multicast the whole activation vector
    logic mac;     // one multiply-accumulate step in every element
  } wsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WLOAD = 2'd1,
    ST_ALOAD = 2'd2,
    ST_MAC   = 2'd3
  } wsState_t;

endpackage

// File: rtl/ws_ctrl.sv
module ws_ctrl
  import ws_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      parMode,
  input  logic      keepWeights,
  output wsStrobe_t stb,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  wsState_t          state;
  logic [CNT_W-1:0]  cnt;
  logic              parQ;
  logic              doneQ;
  logic              phaseEnd;

  assign phaseEnd = (cnt == CNT_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      parQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            parQ  <= parMode;
            cnt   <= '0;
            state <= keepWeights ? ST_ALOAD : ST_WLOAD;
          end
        end
        ST_WLOAD: begin
          if (parQ || phaseEnd) begin
            cnt   <= '0;
            state <= ST_ALOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ALOAD: begin
          if (parQ || phaseEnd) begin
            cnt   <= '0;
            state <= ST_MAC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_MAC: begin
          if (phaseEnd) begin
            cnt   <= '0;
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    case (state)
      ST_WLOAD: begin
        stb.wAll   = parQ;
        stb.wShift = !parQ;
      end
      ST_ALOAD: begin
        stb.aAll   = parQ;
        stb.aShift = !parQ;
      end
      ST_MAC:  stb.mac = 1'b1;
      default: stb = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/ws_pe.sv
module ws_pe #(
  parameter int DW    = 8,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    macEn,
  input  logic signed [DW-1:0]    weight,
  input  logic signed [DW-1:0]    act,
  input  logic signed [ACC_W-1:0] psumIn,
  output logic signed [ACC_W-1:0] psumOut
);

  localparam int PW = 2 * DW;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prodExt;

  assign prod    = act * weight;
  assign prodExt = {{(ACC_W - PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rstN)      psumOut <= '0;
    else if (macEn) psumOut <= psumIn + prodExt;
  end

endmodule

// File: rtl/ws_datapath.sv
module ws_datapath
  import ws_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DW    = 8,
  parameter int ACC_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wsStrobe_t                 stb,
  input  logic [ROWS*COLS*DW-1:0]   wData,
  input  logic [ROWS*DW-1:0]        aData,
  output logic [COLS*ACC_W-1:0]     psum
);

  logic signed [DW-1:0]    wReg   [ROWS][COLS];
  logic signed [DW-1:0]    actReg [ROWS];
  logic signed [ACC_W-1:0] chain  [ROWS+1][COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign chain[0][c] = '0;
    assign psum[c*ACC_W +: ACC_W] = chain[ROWS][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // activation register: multicast or shifted down from the row above
    if (r == 0) begin : g_a0
      always_ff @(posedge clk) begin
        if (!rstN)           actReg[r] <= '0;
        else if (stb.aAll)   actReg[r] <= aData[r*DW +: DW];
        else if (stb.aShift) actReg[r] <= aData[DW-1:0];
      end
    end else begin : g_an
      always_ff @(posedge clk) begin
        if (!rstN)           actReg[r] <= '0;
        else if (stb.aAll)   actReg[r] <= aData[r*DW +: DW];
        else if (stb.aShift) actReg[r] <= actReg[r-1];
      end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (r == 0) begin : g_w0
        always_ff @(posedge clk) begin
          if (!rstN)           wReg[r][c] <= '0;
          else if (stb.wAll)   wReg[r][c] <= wData[(r*COLS+c)*DW +: DW];
          else if (stb.wShift) wReg[r][c] <= wData[c*DW +: DW];
        end
      end else begin : g_wn
        always_ff @(posedge clk) begin
          if (!rstN)           wReg[r][c] <= '0;
          else if (stb.wAll)   wReg[r][c] <= wData[(r*COLS+c)*DW +: DW];
          else if (stb.wShift) wReg[r][c] <= wReg[r-1][c];
        end
      end

      ws_pe #(.DW(DW), .ACC_W(ACC_W)) u_pe (
        .clk     (clk),
        .rstN    (rstN),
        .macEn   (stb.mac),
        .weight  (wReg[r][c]),
        .act     (actReg[r]),
        .psumIn  (chain[r][c]),
        .psumOut (chain[r+1][c])
      );
    end
  end

endmodule

// File: rtl/ws_array.sv
module ws_array
  import ws_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DW    = 8,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    parMode,
  input  logic                    keepWeights,
  input  logic [ROWS*COLS*DW-1:0] wData,
  input  logic [ROWS*DW-1:0]      aData,
  output logic                    busy,
  output logic                    wTake,
  output logic                    aTake,
  output logic                    done,
  output logic [COLS*ACC_W-1:0]   psum
);

  wsStrobe_t stb;

  ws_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .parMode     (parMode),
    .keepWeights (keepWeights),
    .stb         (stb),
    .busy        (busy),
    .done        (done)
  );

  ws_datapath #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .ACC_W(ACC_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wData (wData),
    .aData (aData),
    .psum  (psum)
  );

  assign wTake = stb.wShift | stb.wAll;
  assign aTake = stb.aShift | stb.aAll;

endmodule

// File: rtl/ws_array_chk.sv
module ws_array_chk #(
  parameter int ROWS = 4,
  parameter int PW   = 96
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic          wTake,
  input logic          aTake,
  input logic          macEn,
  input logic [PW-1:0] psum
);

  localparam int MC_W = $clog2(ROWS + 1) + 1;

  logic [MC_W-1:0] macCnt;

  always_ff @(posedge clk) begin
    if (!rstN)      macCnt <= '0;
    else if (macEn) macCnt <= macCnt + 1'b1;
    else if (!busy) macCnt <= '0;
  end

  // R10: the MAC phase covers exactly ROWS cycles
  assert_mac_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (macCnt == MC_W'(ROWS)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_psum_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(psum));

  // R2: load and MAC phases never overlap
  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wTake, aTake, macEn}));

  assert_mac_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(macEn) |-> done);

  assert_mac_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    macEn |-> busy);

endmodule

bind ws_array ws_array_chk #(.ROWS(ROWS), .PW(COLS*ACC_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .busy  (busy),
  .done  (done),
  .wTake (wTake),
  .aTake (aTake),
  .macEn (stb.mac),
  .psum  (psum)
);

// File: tb/sim_ws_array.sv
`timescale 1ns/1ps
module sim_ws_array;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = 8;
  localparam int AW   = 24;
  localparam int WTOT = ROWS*COLS*DW;
  localparam int ATOT = ROWS*DW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic parMode = 1'b0;
  logic keepWeights = 1'b0;
  logic [WTOT-1:0] wData = '0;
  logic [ATOT-1:0] aData = '0;
  logic busy, wTake, aTake, done;
  logic [COLS*AW-1:0] psum;

  int total = 0;
  int bad = 0;

  logic [WTOT-1:0] curW = '0;

  // reference model state
  bit mBusy = 0;
  bit mDone = 0;
  int mCnt = 0;
  int mLat = 0;

  always #2.5 clk = ~clk;

  ws_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .ACC_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .parMode(parMode),
    .keepWeights(keepWeights), .wData(wData), .aData(aData),
    .busy(busy), .wTake(wTake), .aTake(aTake), .done(done), .psum(psum)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model: R7 latencies, R9 start ignored while busy
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0;
    end else if (mBusy) begin
      mCnt++;
      if (mCnt == mLat) begin mBusy = 0; mDone = 1; end
      else mDone = 0;
    end else begin
      mDone = 0;
      if (start) begin
        mBusy = 1;
        mCnt = 0;
        mLat = (keepWeights ? 0 : (parMode ? 1 : ROWS)) + (parMode ? 1 : ROWS) + ROWS;
      end
    end
  end

  // per-cycle comparison (R7, R6, R9)
  always @(negedge clk) begin
    if (rstN) begin
      chk(busy === mBusy, "R7/R9 busy", busy, mBusy);
      chk(done === mDone, "R7/R6 done", done, mDone);
    end
  end

  task automatic runTile(input bit par, input bit keep,
                         input logic [WTOT-1:0] wv, input logic [ATOT-1:0] av,
                         input bit poke);
    int wN = 0;
    int aN = 0;
    int it = 0;
    logic [AW-1:0] exp [COLS];
    if (!keep) curW = wv;
    for (int c = 0; c < COLS; c++) begin
      int s = 0;
      for (int r = 0; r < ROWS; r++)
        s += int'($signed(curW[(r*COLS+c)*DW +: DW])) * int'($signed(av[r*DW +: DW]));
      exp[c] = s[AW-1:0];
    end
    @(negedge clk);
    parMode = par; keepWeights = keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (wTake) begin
        if (par) wData = wv;
        else begin
          wData = '0;
          wData[COLS*DW-1:0] = wv[(ROWS-1-wN)*COLS*DW +: COLS*DW];
        end
        wN++;
      end
      if (aTake) begin
        if (par) aData = av;
        else begin
          aData = '0;
          aData[DW-1:0] = av[(ROWS-1-aN)*DW +: DW];
        end
        aN++;
      end
      start = poke && (it == 1);  // R9: stray start while busy
      it++;
      @(negedge clk);
    end
    start = 1'b0;
    // R5: column results
    for (int c = 0; c < COLS; c++)
      chk(psum[c*AW +: AW] === exp[c], "R5 psum", psum[c*AW +: AW], exp[c]);
    // R2/R3/R8: weight beats taken
    chk(wN == (keep ? 0 : (par ? 1 : ROWS)), "R2/R3/R8 wTake count", wN, keep ? 0 : (par ? 1 : ROWS));
    // R2/R4: activation beats taken
    chk(aN == (par ? 1 : ROWS), "R2/R4 aTake count", aN, par ? 1 : ROWS);
    repeat (3) @(negedge clk);
    chk(!busy, "R9 idle after fold", busy, 0);
    for (int c = 0; c < COLS; c++)
      chk(psum[c*AW +: AW] === exp[c], "R6 psum held", psum[c*AW +: AW], exp[c]);
  endtask

  function automatic logic [WTOT-1:0] rndW();
    logic [WTOT-1:0] v;
    for (int i = 0; i < ROWS*COLS; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  function automatic logic [ATOT-1:0] rndA();
    logic [ATOT-1:0] v;
    for (int i = 0; i < ROWS; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  initial begin
    logic [WTOT-1:0] w1;
    logic [ATOT-1:0] a1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(wTake === 1'b0 && aTake === 1'b0, "R1 take", {wTake, aTake}, 0);
    chk(psum === '0, "R1 psum", psum, 0);
    rstN = 1'b1;
    @(negedge clk);

    w1 = rndW(); a1 = rndA();
    runTile(1'b1, 1'b0, w1, a1, 1'b0);        // parallel (R2)
    runTile(1'b0, 1'b0, w1, a1, 1'b0);        // shifting, same data (R3, R4)
    runTile(1'b1, 1'b1, '0, rndA(), 1'b0);    // R8 keep, parallel
    runTile(1'b0, 1'b1, '0, rndA(), 1'b0);    // R8 keep, shifting
    runTile(1'b0, 1'b0, rndW(), rndA(), 1'b0);
    runTile(1'b1, 1'b0, {ROWS*COLS{8'h80}}, {ROWS{8'h80}}, 1'b0);  // extremes
    runTile(1'b0, 1'b0, {ROWS*COLS{8'h7f}}, {ROWS{8'h80}}, 1'b0);
    runTile(1'b0, 1'b0, rndW(), rndA(), 1'b1);  // R9 stray start, shifting
    runTile(1'b1, 1'b0, rndW(), rndA(), 1'b1);  // R9 stray start, parallel
    runTile(1'b1, 1'b0, '0, rndA(), 1'b0);      // zero weights
    for (int k = 0; k < 4; k++)
      runTile(k[0], k[1], rndW(), rndA(), 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule